// File: doc/BRIEF.md
# Power Island On/Off Sequencer

This block steps one switchable logic island through its power-down and power-up procedures. The island has a main power switch (driven by a sleep control), a row of memory banks that each take a multi-bit power-down field, an output isolation clamp, an active-high island reset and a clock enable. A single request transfer selects either an ON or an OFF run. The sequencer then drives those five controls in a fixed order, with a short wait and a long wait set in clock cycles by parameters.

The two directions use different orders. Going down, the switch is opened first, then the memories are powered down, then the clamp is applied, and only after the long wait are the clocks gated. Going up, the switch closes and the memories wake, each followed by the short wait. The island reset is then asserted, the clamp is released while reset is held, reset is released, and the clock is enabled last. A strap sampled during reset can mark an island that is already running as locked on. A shutdown input runs the power-down only when the island is actually powered. A variant without a main switch keeps only the memory steps and the waits.

Top module: `pwr_island_seq`

## Requirements
- R1: With the strap low, reset leaves sleep_o=1, every mem_pd_o bit 1, iso_o=1, island_rst_o=1, clk_en_o=0, powered_off_o=1, busy_o=0 and req_ready_o=1.
- R2: With the strap high and a main switch present, reset leaves the island powered: sleep_o=0, mem_pd_o all zero, iso_o=0, island_rst_o=0, clk_en_o=1, powered_off_o=0. The island is then locked on.
- R3: The transfer edge of an OFF run is edge 0. sleep_o rises after edge 1, mem_pd_o goes all ones after edge SHORT_WAIT+2, iso_o rises after edge 2*SHORT_WAIT+3, and clk_en_o falls after edge 2*SHORT_WAIT+LONG_WAIT+4. island_rst_o is not touched.
- R4: The transfer edge of an ON run is edge 0. sleep_o falls after edge 1 and mem_pd_o clears after edge SHORT_WAIT+2. island_rst_o is high after edge 2*SHORT_WAIT+3, iso_o falls after edge 2*SHORT_WAIT+4, island_rst_o falls after edge 2*SHORT_WAIT+5, and clk_en_o rises after edge 2*SHORT_WAIT+6.
- R5: done_o is high for exactly one cycle per completed run. It rises on the same edge as the last step of that run.
- R6: A request transfers on a rising edge where req_valid_i and req_ready_o are both high. req_on_i=1 selects ON and req_on_i=0 selects OFF. req_ready_o is high only while no run is active and shutdown_i is low (for the switched variant), and busy_o is high throughout a run.
- R7: An OFF request to a locked-on island is taken and then dropped. No output changes and done_o does not pulse.
- R8: When idle, shutdown_i=1 with sleep_o=0 starts an OFF run, even on a locked island, and it wins over a request in the same cycle. With sleep_o=1 it has no effect.
- R9: powered_off_o equals sleep_o when a main switch is present. Without one, it is the AND of all memory field bits.
- R10: Without a main switch (HAS_TOP=0), sleep_o and iso_o stay 0. The memory steps keep the timing of R3 and R4. The strap and shutdown_i are ignored, and after reset the memories are powered down.
- R11: Bank i owns mem_pd_o[i*MEM_W +: MEM_W]. Power-down sets all bits of every field, and power-up clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| aon_strap_i | input | 1 | Sampled in reset: island already powered |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (idle) |
| req_on_i | input | 1 | Request direction, 1 = ON, 0 = OFF |
| shutdown_i | input | 1 | Global shutdown request |
| sleep_o | output | 1 | Main switch sleep control, 1 = switch open |
| mem_pd_o | output | N_MEM*MEM_W | Memory bank power-down fields |
| iso_o | output | 1 | Output isolation clamp |
| island_rst_o | output | 1 | Island reset, active high |
| clk_en_o | output | 1 | Island clock enable |
| busy_o | output | 1 | A run is active |
| done_o | output | 1 | One-cycle completion pulse |
| powered_off_o | output | 1 | Island power state |

## Verification
The bench starts from both strap settings and sweeps every three-step mix of ON, OFF and shutdown. For each step it predicts the exact change cycle of each output, so a design that swapped the clamp release with the reset assert, or waited one cycle too few, is caught at that output's timestamp. It also checks repeated ON runs, where only the reset pulse appears, and OFF runs on an island that is already off. A design that ignored the lock would power down a strapped island. One that ran shutdown on an island already off would produce a stray done pulse. Requests during a run and a shutdown that collides with a request are also covered, and a switchless instance must keep its clamp and sleep low.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OFF_SLEEP, ST_OFF_W1, ST_OFF_MEM, ST_OFF_W2, ST_OFF_ISO, ST_OFF_WL, ST_OFF_CLK,
    ST_ON_SLEEP, ST_ON_W1, ST_ON_MEM, ST_ON_W2, ST_ON_RST, ST_ON_ISO, ST_ON_UNRST, ST_ON_CLK
  } seq_st_e;

  typedef struct packed {
    logic sleep_set;
    logic sleep_clr;
    logic mem_set;
    logic mem_clr;
    logic iso_set;
    logic iso_clr;
    logic rst_set;
    logic rst_clr;
    logic clk_off;
    logic clk_on;
  } step_t;

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R3
  count_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned SHORT_WAIT = 1000,
  parameter int unsigned LONG_WAIT  = 1000000,
  parameter int unsigned CW         = 20
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go_on,
  input  logic  go_off,
  output logic  idle,
  output step_t step,
  output logic  done_o
);

  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_WAIT - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_WAIT - 1);

  seq_st_e       state_q, state_d;
  logic          tmr_load, expired, fin, done_q;
  logic [CW-1:0] tmr_val;

  pwr_seq_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  always_comb begin
    state_d  = state_q;
    step     = '0;
    tmr_load = 1'b0;
    tmr_val  = SHORT_LD;
    fin      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go_off)     state_d = ST_OFF_SLEEP;
        else if (go_on) state_d = ST_ON_SLEEP;
      end
      ST_OFF_SLEEP: begin step.sleep_set = 1'b1; tmr_load = 1'b1; state_d = ST_OFF_W1; end
      ST_OFF_W1:    if (expired) state_d = ST_OFF_MEM;
      ST_OFF_MEM:   begin step.mem_set = 1'b1; tmr_load = 1'b1; state_d = ST_OFF_W2; end
      ST_OFF_W2:    if (expired) state_d = ST_OFF_ISO;
      ST_OFF_ISO: begin
        step.iso_set = 1'b1;
        tmr_load     = 1'b1;
        tmr_val      = LONG_LD;
        state_d      = ST_OFF_WL;
      end
      ST_OFF_WL:    if (expired) state_d = ST_OFF_CLK;
      ST_OFF_CLK:   begin step.clk_off = 1'b1; fin = 1'b1; state_d = ST_IDLE; end
      ST_ON_SLEEP:  begin step.sleep_clr = 1'b1; tmr_load = 1'b1; state_d = ST_ON_W1; end
      ST_ON_W1:     if (expired) state_d = ST_ON_MEM;
      ST_ON_MEM:    begin step.mem_clr = 1'b1; tmr_load = 1'b1; state_d = ST_ON_W2; end
      ST_ON_W2:     if (expired) state_d = ST_ON_RST;
      ST_ON_RST:    begin step.rst_set = 1'b1; state_d = ST_ON_ISO; end
      ST_ON_ISO:    begin step.iso_clr = 1'b1; state_d = ST_ON_UNRST; end
      ST_ON_UNRST:  begin step.rst_clr = 1'b1; state_d = ST_ON_CLK; end
      ST_ON_CLK:    begin step.clk_on = 1'b1; fin = 1'b1; state_d = ST_IDLE; end
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
    end
  end

  assign idle   = (state_q == ST_IDLE);
  assign done_o = done_q;

  // R6
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_on || go_off) |-> (state_q == ST_IDLE));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/pwr_seq_outs.sv
module pwr_seq_outs
  import pwr_seq_pkg::*;
#(
  parameter int unsigned N_MEM   = 4,
  parameter int unsigned MEM_W   = 2,
  parameter int unsigned HAS_TOP = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   aon_i,
  input  step_t                  step,
  output logic                   sleep_o,
  output logic [N_MEM*MEM_W-1:0] mem_pd_o,
  output logic                   iso_o,
  output logic                   rst_o,
  output logic                   clk_en_o
);

  localparam int unsigned MW  = N_MEM * MEM_W;
  localparam logic        TOP = (HAS_TOP != 0);

  logic          aon_eff;
  logic          sleep_q, iso_q, rst_q, clk_q;
  logic [MW-1:0] mem_q;

  assign aon_eff = aon_i & TOP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sleep_q <= TOP & ~aon_eff;
      iso_q   <= TOP & ~aon_eff;
      rst_q   <= ~aon_eff;
      clk_q   <= aon_eff;
    end else begin
      if (TOP) begin
        if (step.sleep_set)      sleep_q <= 1'b1;
        else if (step.sleep_clr) sleep_q <= 1'b0;
        if (step.iso_set)        iso_q   <= 1'b1;
        else if (step.iso_clr)   iso_q   <= 1'b0;
      end
      if (step.rst_set)          rst_q   <= 1'b1;
      else if (step.rst_clr)     rst_q   <= 1'b0;
      if (step.clk_on)           clk_q   <= 1'b1;
      else if (step.clk_off)     clk_q   <= 1'b0;
    end
  end

  for (genvar g = 0; g < N_MEM; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)             mem_q[g*MEM_W +: MEM_W] <= aon_eff ? '0 : '1;
      else if (step.mem_set)  mem_q[g*MEM_W +: MEM_W] <= '1;
      else if (step.mem_clr)  mem_q[g*MEM_W +: MEM_W] <= '0;
    end
  end

  assign sleep_o  = sleep_q;
  assign iso_o    = iso_q;
  assign rst_o    = rst_q;
  assign clk_en_o = clk_q;
  assign mem_pd_o = mem_q;

  // R4
  iso_under_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_q) |-> rst_q);

  // R4
  clk_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_q) |-> (!rst_q && !iso_q && mem_q == '0));

  // R3
  iso_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_q) |-> (&mem_q && sleep_q));

  // R3
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_q) |-> (&mem_q && (iso_q || !TOP)));

  // R3
  sleep_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_q) |-> (mem_q == '0));

endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned N_MEM      = 4,
  parameter int unsigned MEM_W      = 2,
  parameter int unsigned HAS_TOP    = 1,
  parameter int unsigned SHORT_WAIT = 1000,
  parameter int unsigned LONG_WAIT  = 1000000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   aon_strap_i,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_on_i,
  input  logic                   shutdown_i,
  output logic                   sleep_o,
  output logic [N_MEM*MEM_W-1:0] mem_pd_o,
  output logic                   iso_o,
  output logic                   island_rst_o,
  output logic                   clk_en_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   powered_off_o
);

  localparam logic        TOP  = (HAS_TOP != 0);
  localparam int unsigned MAXW = (SHORT_WAIT > LONG_WAIT) ? SHORT_WAIT : LONG_WAIT;
  localparam int unsigned CW   = $clog2(MAXW + 1);

  logic  idle, locked_q, sd_take, fire, go_on, go_off;
  step_t step;

  always_ff @(posedge clk) begin
    if (!rst_n) locked_q <= aon_strap_i & TOP;
  end

  assign sd_take     = idle & shutdown_i & TOP & ~sleep_o;
  assign req_ready_o = idle & ~(shutdown_i & TOP);
  assign fire        = req_valid_i & req_ready_o;
  assign go_off      = sd_take | (fire & ~req_on_i & ~locked_q);
  assign go_on       = fire & req_on_i;
  assign busy_o      = ~idle;

  pwr_seq_fsm #(
    .SHORT_WAIT (SHORT_WAIT),
    .LONG_WAIT  (LONG_WAIT),
    .CW         (CW)
  ) i_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_on  (go_on),
    .go_off (go_off),
    .idle   (idle),
    .step   (step),
    .done_o (done_o)
  );

  pwr_seq_outs #(
    .N_MEM   (N_MEM),
    .MEM_W   (MEM_W),
    .HAS_TOP (HAS_TOP)
  ) i_outs (
    .clk      (clk),
    .rst_n    (rst_n),
    .aon_i    (aon_strap_i),
    .step     (step),
    .sleep_o  (sleep_o),
    .mem_pd_o (mem_pd_o),
    .iso_o    (iso_o),
    .rst_o    (island_rst_o),
    .clk_en_o (clk_en_o)
  );

  if (TOP) begin : g_status_top
    assign powered_off_o = sleep_o;
  end else begin : g_status_mem
    assign powered_off_o = &mem_pd_o;
  end

  // R7
  lock_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && fire && !req_on_i) |=> !busy_o);

  // R8
  shutdown_off_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (TOP && idle && shutdown_i && sleep_o) |=> !busy_o);

  // R8
  shutdown_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (TOP && idle && shutdown_i && !sleep_o) |=> (busy_o && !req_ready_o));

endmodule

// File: tb/test_pwr_island_seq.sv
`timescale 1ns/1ps
module test_pwr_island_seq;

  localparam int S  = 3;
  localparam int L  = 9;
  localparam int NM = 4;
  localparam int MW_ = 2;
  localparam int MW = NM * MW_;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0, valid = 1'b0, on = 1'b0, sd = 1'b0;
  logic ready, sleep, iso, irst, clken, busy, done, poff;
  logic [MW-1:0] mem;
  logic m_valid = 1'b0, m_on = 1'b0, m_sd = 1'b0;
  logic m_ready, m_sleep, m_iso, m_irst, m_clken, m_busy, m_done, m_poff;
  logic [MW-1:0] m_mem;

  int nchk = 0, nfail = 0, cyc = 0, n_done = 0;
  int t_sleep = 0, t_mem = 0, t_iso = 0, t_clk = 0, t_rr = 0, t_rf = 0, t_done = 0;
  logic p_sleep = 1'b0, p_iso = 1'b0, p_clk = 1'b0, p_rst = 1'b0;
  logic [MW-1:0] p_mem = '0;
  bit m_on_st, m_lock, m_rst, finished = 1'b0;

  always #10 clk = ~clk;

  pwr_island_seq #(.N_MEM(NM), .MEM_W(MW_), .HAS_TOP(1), .SHORT_WAIT(S), .LONG_WAIT(L)) i_pwr_island_seq (
    .clk(clk), .rst_n(rst_n), .aon_strap_i(strap), .req_valid_i(valid), .req_ready_o(ready),
    .req_on_i(on), .shutdown_i(sd), .sleep_o(sleep), .mem_pd_o(mem), .iso_o(iso),
    .island_rst_o(irst), .clk_en_o(clken), .busy_o(busy), .done_o(done), .powered_off_o(poff));

  pwr_island_seq #(.N_MEM(NM), .MEM_W(MW_), .HAS_TOP(0), .SHORT_WAIT(S), .LONG_WAIT(L)) i_pwr_island_seq_m (
    .clk(clk), .rst_n(rst_n), .aon_strap_i(1'b1), .req_valid_i(m_valid), .req_ready_o(m_ready),
    .req_on_i(m_on), .shutdown_i(m_sd), .sleep_o(m_sleep), .mem_pd_o(m_mem), .iso_o(m_iso),
    .island_rst_o(m_irst), .clk_en_o(m_clken), .busy_o(m_busy), .done_o(m_done), .powered_off_o(m_poff));

  always @(negedge clk) begin
    cyc++;
    if (sleep !== p_sleep) t_sleep = cyc;
    if (mem !== p_mem) t_mem = cyc;
    if (iso !== p_iso) t_iso = cyc;
    if (clken !== p_clk) t_clk = cyc;
    if (irst === 1'b1 && p_rst === 1'b0) t_rr = cyc;
    if (irst === 1'b0 && p_rst === 1'b1) t_rf = cyc;
    if (done === 1'b1) begin t_done = cyc; n_done++; end
    p_sleep = sleep; p_mem = mem; p_iso = iso; p_clk = clken; p_rst = irst;
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic check_state(string tag);
    chk({tag, " sleep"}, int'(sleep), m_on_st ? 0 : 1);
    chk({tag, " mem"}, int'(mem), m_on_st ? 0 : 255);
    chk({tag, " iso"}, int'(iso), m_on_st ? 0 : 1);
    chk({tag, " rst"}, int'(irst), int'(m_rst));
    chk({tag, " clk"}, int'(clken), m_on_st ? 1 : 0);
    chk({tag, " R9 poff"}, int'(poff), int'(sleep));
  endtask

  task automatic do_reset(bit s);
    @(negedge clk); #1;
    rst_n = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    m_on_st = s; m_lock = s; m_rst = !s;
    @(negedge clk); #1;
    check_state(s ? "R2 reset" : "R1 reset");
    chk("R1 busy", int'(busy), 0);
    chk("R1 ready", int'(ready), 1);
  endtask

  // op: 0 = ON request, 1 = OFF request, 2 = shutdown
  task automatic do_op(int op);
    int c0, nd0;
    bit eff, was_on;
    @(negedge clk); #1;
    c0 = cyc; nd0 = n_done;
    chk("R6 ready idle", int'(ready), 1);
    if (op == 2) sd = 1'b1; else begin valid = 1'b1; on = (op == 0); end
    @(negedge clk); #1;
    sd = 1'b0; valid = 1'b0;
    eff = (op == 0) || (op == 1 && !m_lock) || (op == 2 && m_on_st);
    was_on = m_on_st;
    while (cyc < c0 + 2*S + L + 12) @(negedge clk);
    #1;
    if (!eff) begin
      chk(op == 1 ? "R7 no done" : "R8 no done", n_done - nd0, 0);
    end else begin
      chk("R5 one done cycle", n_done - nd0, 1);
      if (op == 0) begin
        chk("R5 done time", t_done, c0 + 2*S + 7);
        chk("R4 rst release", t_rf, c0 + 2*S + 6);
        if (!m_rst) chk("R4 rst assert", t_rr, c0 + 2*S + 4);
        if (!was_on) begin
          chk("R4 sleep clr", t_sleep, c0 + 2);
          chk("R4 R11 mem clr", t_mem, c0 + S + 3);
          chk("R4 iso release", t_iso, c0 + 2*S + 5);
          chk("R4 clk en", t_clk, c0 + 2*S + 7);
        end
        m_on_st = 1'b1; m_rst = 1'b0;
      end else begin
        chk("R5 done time", t_done, c0 + 2*S + L + 5);
        if (was_on) begin
          chk("R3 sleep set", t_sleep, c0 + 2);
          chk("R3 R11 mem set", t_mem, c0 + S + 3);
          chk("R3 iso set", t_iso, c0 + 2*S + 4);
          chk("R3 clk gate", t_clk, c0 + 2*S + L + 5);
        end
        m_on_st = 1'b0;
      end
    end
    check_state(op == 0 ? "R4 final" : (op == 1 ? "R7 R3 final" : "R8 final"));
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 27; p++) begin
        do_reset(s[0]);
        do_op(p % 3);
        do_op((p / 3) % 3);
        do_op(p / 9);
      end
    end

    // R6: request during a run is not accepted
    do_reset(1'b0);
    begin
      int nd0;
      nd0 = n_done;
      @(negedge clk); #1 valid = 1'b1; on = 1'b1;
      @(negedge clk); #1 valid = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R6 ready low in run", int'(ready), 0);
      chk("R6 busy in run", int'(busy), 1);
      valid = 1'b1; on = 1'b0;
      @(negedge clk); #1 valid = 1'b0;
      repeat (2*S + L + 12) @(negedge clk);
      #1;
      chk("R6 one run only", n_done - nd0, 1);
      chk("R6 stayed on", int'(sleep), 0);
      chk("R6 clk on", int'(clken), 1);
    end

    // R8: shutdown wins over a same-cycle request
    @(negedge clk); #1 sd = 1'b1; valid = 1'b1; on = 1'b1;
    #1 chk("R8 ready low with shutdown", int'(ready), 0);
    @(negedge clk); #1 sd = 1'b0; valid = 1'b0;
    repeat (2*S + L + 12) @(negedge clk);
    #1;
    chk("R8 shutdown powered down", int'(sleep), 1);
    chk("R8 shutdown clk gated", int'(clken), 0);

    // R10: switchless variant
    do_reset(1'b0);
    chk("R10 sleep low", int'(m_sleep), 0);
    chk("R10 iso low", int'(m_iso), 0);
    chk("R10 mem off after reset", int'(m_mem), 255);
    chk("R9 R10 poff", int'(m_poff), 1);
    @(negedge clk); #1 m_sd = 1'b1;
    @(negedge clk); #1 m_sd = 1'b0;
    chk("R10 shutdown ignored", int'(m_busy), 0);
    @(negedge clk); #1 m_valid = 1'b1; m_on = 1'b1;
    @(negedge clk); #1 m_valid = 1'b0;
    repeat (S + 1) @(negedge clk);
    #1 chk("R10 mem before step", int'(m_mem), 255);
    @(negedge clk); #1 chk("R10 R11 mem cleared", int'(m_mem), 0);
    repeat (2*S + 8) @(negedge clk);
    #1;
    chk("R10 clk on", int'(m_clken), 1);
    chk("R10 iso still low", int'(m_iso), 0);
    chk("R9 R10 poff on", int'(m_poff), 0);
    @(negedge clk); #1 m_valid = 1'b1; m_on = 1'b0;
    @(negedge clk); #1 m_valid = 1'b0;
    repeat (2*S + L + 12) @(negedge clk);
    #1;
    chk("R10 mem off", int'(m_mem), 255);
    chk("R10 sleep stays low", int'(m_sleep), 0);
    chk("R9 R10 poff off", int'(m_poff), 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(150000 * 20);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule